// File: doc/BRIEF.md
# Fault-Input Conditioner with Output-Enable Control

This block watches an external fault line, and an internal system fault flag, on behalf of a power-stage timer. It owns the single master output-enable bit that gates every driven output. The fault pin is first mapped to an "active" sense by a polarity setting. Next it passes through a digital filter. A 4-bit code picks the sampling rate (every kernel clock, or the dead-time clock strobe divided by 2 to 32) and how many agreeing samples are needed before the filtered level may change. Code zero bypasses the filter and lets the fault act combinationally. Any active fault forces the master enable low at once. Software may raise the enable again, and so may an update event when automatic re-enable is chosen, but neither has any effect while a fault persists.

In bidirectional mode the block also signals faults outward: while a fault is seen, it pulls the shared fault pin low as an open-drain driver. Software may disarm this pull, which releases the pin to high impedance. Hardware re-arms it by clearing the disarm flag once no fault source remains active. All interfaces are plain level or pulse control pins; nothing streams through the block, so there is no valid/ready handshake.

Top module: `brk_guard`

## Requirements
- R1: After reset, oe_o, brk_active_o, disarmed_o and brk_pin_pull_low_o are all 0.
- R2: With cfg_polarity=1 the pin is active when high, and with cfg_polarity=0 it is active when low. While cfg_enable=0, brk_active_o stays 0 whatever the pin and sys_brk_i do.
- R3: With cfg_filt=0 the fault is combinational: brk_active_o rises and oe_o falls in the same cycle that the active pin level appears, before any clock edge.
- R4: Codes 1, 2 and 3 sample the pin on every clock and need 2, 4 and 8 consecutive agreeing samples. The filtered level changes on the clock edge of the last one, and a single sample that agrees with the current filtered level restarts the count.
- R5: Codes 4..15 sample only on every 2^k-th dts_en strobe. The divisor and sample count per code are: 4:/2,6  5:/2,8  6:/4,6  7:/4,8  8:/8,6  9:/8,8  10:/16,5  11:/16,6  12:/16,8  13:/32,5  14:/32,6  15:/32,8. Without dts_en strobes the filtered level never changes.
- R6: While brk_active_o is 1, oe_o is 0, and a sw_oe_set pulse leaves oe_o at 0. The enable stays 0 after the fault ends until something sets it again.
- R7: An update_evt pulse sets oe_o on the following edge only if cfg_auto=1 and no fault is active.
- R8: A sw_oe_set pulse with no fault sets oe_o on the next edge, and a sw_oe_clr pulse clears it. oe_o never rises without one of these causes.
- R9: brk_pin_pull_low_o is 1 only with cfg_bidir=1 and disarmed_o=0. It follows an active fault one edge later and is never driven in input mode (cfg_bidir=0).
- R10: A sw_disarm pulse sets disarmed_o and releases the pull on the next edge. disarmed_o stays 1 while any fault source is active, and hardware clears it on the first edge at which none is.
- R11: sys_brk_i=1 with cfg_enable=1 is a fault with the same effects as an active pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Fault detection enable |
| cfg_polarity | input | 1 | 1: pin active high, 0: pin active low |
| cfg_filt | input | 4 | Filter code (rate and sample count) |
| cfg_auto | input | 1 | Allow update events to re-enable outputs |
| cfg_bidir | input | 1 | Open-drain signalling of faults on the pin |
| dts_en | input | 1 | Dead-time clock strobe, one cycle per period |
| brk_pin_i | input | 1 | Fault pin level as seen at the pad |
| sys_brk_i | input | 1 | Internal system fault, active high |
| update_evt | input | 1 | Timer update event pulse |
| sw_oe_set | input | 1 | Software request to raise the output enable |
| sw_oe_clr | input | 1 | Software request to lower the output enable |
| sw_disarm | input | 1 | Software request to release the pin pull |
| oe_o | output | 1 | Master output enable |
| brk_active_o | output | 1 | Conditioned fault, active high |
| disarmed_o | output | 1 | Pin pull currently disarmed |
| brk_pin_pull_low_o | output | 1 | Drive the fault pin low (open drain) |

## Verification
The bound checker watches, on every cycle, the invariants: the enable is low whenever a fault is active, the enable rises only after a set request or a permitted update, the pin pull is only present in bidirectional mode while armed, the disarm flag cannot drop while a source is active, and disabling detection masks every fault. The filter's timing per code, the restart of the count on an agreeing sample, the stall without dead-time strobes, and the same-cycle path of the unfiltered mode are latency and ordering facts. Only the bench's scenarios show these, by counting clocks from stimulus to response. The bench also models the shared pin so that the self-sustaining pull and its software release can be shown end to end.

// File: rtl/brk_guard_pkg.sv
package brk_guard_pkg;
  localparam int unsigned FILT_CODE_W = 4;
  localparam int unsigned MAX_DIV_LOG = 5;
  localparam int unsigned DIV_SEL_W   = $clog2(MAX_DIV_LOG + 1);
  localparam int unsigned NEED_W      = 4;

  typedef struct packed {
    logic [DIV_SEL_W-1:0] div_log; // 0: every kernel clock, k: every 2^k dts strobes
    logic [NEED_W-1:0]    need;    // consecutive samples required
    logic                 bypass;  // unfiltered, combinational path
  } filt_cfg_t;

  function automatic filt_cfg_t decode_filt(input logic [FILT_CODE_W-1:0] code);
    filt_cfg_t c;
    c.bypass = 1'b0;
    case (code)
      4'd0:  begin c.div_log = 3'd0; c.need = 4'd1; c.bypass = 1'b1; end
      4'd1:  begin c.div_log = 3'd0; c.need = 4'd2; end
      4'd2:  begin c.div_log = 3'd0; c.need = 4'd4; end
      4'd3:  begin c.div_log = 3'd0; c.need = 4'd8; end
      4'd4:  begin c.div_log = 3'd1; c.need = 4'd6; end
      4'd5:  begin c.div_log = 3'd1; c.need = 4'd8; end
      4'd6:  begin c.div_log = 3'd2; c.need = 4'd6; end
      4'd7:  begin c.div_log = 3'd2; c.need = 4'd8; end
      4'd8:  begin c.div_log = 3'd3; c.need = 4'd6; end
      4'd9:  begin c.div_log = 3'd3; c.need = 4'd8; end
      4'd10: begin c.div_log = 3'd4; c.need = 4'd5; end
      4'd11: begin c.div_log = 3'd4; c.need = 4'd6; end
      4'd12: begin c.div_log = 3'd4; c.need = 4'd8; end
      4'd13: begin c.div_log = 3'd5; c.need = 4'd5; end
      4'd14: begin c.div_log = 3'd5; c.need = 4'd6; end
      default: begin c.div_log = 3'd5; c.need = 4'd8; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/brk_tick_gen.sv
module brk_tick_gen #(
  parameter int unsigned MAX_LOG = 5,
  parameter int unsigned SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dts_en,
  input  logic [SEL_W-1:0] div_log,
  output logic             tick
);
  logic [MAX_LOG-1:0] dcnt;
  logic [MAX_LOG:0]   tick_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dcnt <= '0;
    else if (dts_en) dcnt <= dcnt + 1'b1;
  end

  assign tick_vec[0] = 1'b1;
  for (genvar k = 1; k <= MAX_LOG; k++) begin : g_div
    assign tick_vec[k] = dts_en & (&dcnt[k-1:0]);
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i <= MAX_LOG; i++)
      if (div_log == SEL_W'(i)) tick = tick_vec[i];
  end
endmodule

// File: rtl/brk_filter.sv
module brk_filter #(
  parameter int unsigned NEED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_in,
  input  logic              tick,
  input  logic              bypass,
  input  logic [NEED_W-1:0] need,
  output logic              level_q
);
  logic [NEED_W-1:0] run_cnt;
  logic              last;

  assign last = (run_cnt == need - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_cnt <= '0;
    end else if (bypass) begin
      level_q <= sample_in;
      run_cnt <= '0;
    end else if (tick) begin
      if (sample_in == level_q) begin
        run_cnt <= '0;
      end else if (last) begin
        level_q <= sample_in;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/brk_oe_ctrl.sv
module brk_oe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic auto_en,
  input  logic update_evt,
  input  logic sw_set,
  input  logic sw_clr,
  output logic oe
);
  logic oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     oe_q <= 1'b0;
    else if (fault)                 oe_q <= 1'b0;
    else if (sw_clr)                oe_q <= 1'b0;
    else if (sw_set)                oe_q <= 1'b1;
    else if (auto_en && update_evt) oe_q <= 1'b1;
  end

  // Fault masks the enable without waiting for a clock edge.
  assign oe = oe_q & ~fault;
endmodule

// File: rtl/brk_bidir_ctrl.sv
module brk_bidir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic bidir,
  input  logic sw_disarm,
  output logic disarmed,
  output logic pull_low
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      disarmed <= 1'b0;
    end else begin
      seen_q <= fault;
      if (sw_disarm)   disarmed <= 1'b1;
      else if (!fault) disarmed <= 1'b0;
    end
  end

  assign pull_low = bidir & ~disarmed & seen_q;
endmodule

// File: rtl/brk_guard.sv
module brk_guard
  import brk_guard_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_enable,
  input  logic                   cfg_polarity,
  input  logic [FILT_CODE_W-1:0] cfg_filt,
  input  logic                   cfg_auto,
  input  logic                   cfg_bidir,
  input  logic                   dts_en,
  input  logic                   brk_pin_i,
  input  logic                   sys_brk_i,
  input  logic                   update_evt,
  input  logic                   sw_oe_set,
  input  logic                   sw_oe_clr,
  input  logic                   sw_disarm,
  output logic                   oe_o,
  output logic                   brk_active_o,
  output logic                   disarmed_o,
  output logic                   brk_pin_pull_low_o
);
  filt_cfg_t fcfg;
  logic      raw_pin;
  logic      tick;
  logic      filt_q;
  logic      pin_fault;
  logic      brk_any;

  assign fcfg    = decode_filt(cfg_filt);
  assign raw_pin = cfg_enable & (cfg_polarity ? brk_pin_i : ~brk_pin_i);

  brk_tick_gen #(.MAX_LOG(MAX_DIV_LOG), .SEL_W(DIV_SEL_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .dts_en(dts_en),
    .div_log(fcfg.div_log), .tick(tick)
  );

  brk_filter #(.NEED_W(NEED_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .sample_in(raw_pin), .tick(tick),
    .bypass(fcfg.bypass), .need(fcfg.need), .level_q(filt_q)
  );

  assign pin_fault    = fcfg.bypass ? raw_pin : filt_q;
  assign brk_any      = cfg_enable & (pin_fault | sys_brk_i);
  assign brk_active_o = brk_any;

  brk_oe_ctrl u_oe (
    .clk(clk), .rst_n(rst_n), .fault(brk_any), .auto_en(cfg_auto),
    .update_evt(update_evt), .sw_set(sw_oe_set), .sw_clr(sw_oe_clr), .oe(oe_o)
  );

  brk_bidir_ctrl u_bidir (
    .clk(clk), .rst_n(rst_n), .fault(brk_any), .bidir(cfg_bidir),
    .sw_disarm(sw_disarm), .disarmed(disarmed_o), .pull_low(brk_pin_pull_low_o)
  );
endmodule

// File: rtl/brk_guard_chk.sv
module brk_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_auto,
  input logic cfg_bidir,
  input logic update_evt,
  input logic sw_oe_set,
  input logic brk_any,
  input logic oe_o,
  input logic brk_active_o,
  input logic disarmed_o,
  input logic brk_pin_pull_low_o
);
  p_oe_off_in_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active_o |-> !oe_o);

  p_oe_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_o && !sw_oe_set && !(update_evt && cfg_auto)) |=> !oe_o);

  p_pull_needs_armed_bidir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pin_pull_low_o |-> (cfg_bidir && !disarmed_o));

  p_disarm_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disarmed_o && brk_any) |=> disarmed_o);

  p_disabled_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !brk_active_o);
endmodule

bind brk_guard brk_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_auto(cfg_auto),
  .cfg_bidir(cfg_bidir), .update_evt(update_evt), .sw_oe_set(sw_oe_set),
  .brk_any(brk_any), .oe_o(oe_o), .brk_active_o(brk_active_o),
  .disarmed_o(disarmed_o), .brk_pin_pull_low_o(brk_pin_pull_low_o)
);

// File: tb/brk_guard_bench.sv
`timescale 1ns/1ps
module brk_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b1, cfg_polarity = 1'b1, cfg_auto = 1'b0, cfg_bidir = 1'b0;
  logic [3:0] cfg_filt = 4'd0;
  logic dts_en = 1'b1, ext_lvl = 1'b0, sys_brk = 1'b0, update_evt = 1'b0;
  logic sw_oe_set = 1'b0, sw_oe_clr = 1'b0, sw_disarm = 1'b0;
  logic oe, active, disarmed, pull_low, pin;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign pin = pull_low ? 1'b0 : ext_lvl;

  brk_guard u_brk_guard (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_polarity(cfg_polarity),
    .cfg_filt(cfg_filt), .cfg_auto(cfg_auto), .cfg_bidir(cfg_bidir), .dts_en(dts_en),
    .brk_pin_i(pin), .sys_brk_i(sys_brk), .update_evt(update_evt),
    .sw_oe_set(sw_oe_set), .sw_oe_clr(sw_oe_clr), .sw_disarm(sw_disarm),
    .oe_o(oe), .brk_active_o(active), .disarmed_o(disarmed), .brk_pin_pull_low_o(pull_low)
  );

  // {code, log2 divisor, samples needed}
  localparam logic [11:0] FILT_VEC [15] = '{
    {4'd1, 4'd0, 4'd2}, {4'd2, 4'd0, 4'd4}, {4'd3, 4'd0, 4'd8},
    {4'd4, 4'd1, 4'd6}, {4'd5, 4'd1, 4'd8}, {4'd6, 4'd2, 4'd6},
    {4'd7, 4'd2, 4'd8}, {4'd8, 4'd3, 4'd6}, {4'd9, 4'd3, 4'd8},
    {4'd10, 4'd4, 4'd5}, {4'd11, 4'd4, 4'd6}, {4'd12, 4'd4, 4'd8},
    {4'd13, 4'd5, 4'd5}, {4'd14, 4'd5, 4'd6}, {4'd15, 4'd5, 4'd8}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk("R1 oe after reset", oe, 0);
    chk("R1 active after reset", active, 0);
    chk("R1 disarmed after reset", disarmed, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 pull after reset", pull_low, 0);

    // Filter table walk (R4 kernel codes, R5 divided codes)
    dts_en = 1'b1;
    for (int v = 0; v < 15; v++) begin
      int lat, lo, hi, d, n;
      cfg_filt = FILT_VEC[v][11:8];
      d = 1 << FILT_VEC[v][7:4];
      n = int'(FILT_VEC[v][3:0]);
      ext_lvl = 1'b0;
      for (int w = 0; w < 400 && active; w++) @(negedge clk);
      cyc(2);
      ext_lvl = 1'b1;
      lat = 0;
      for (int w = 0; w < 400 && !active; w++) begin
        @(negedge clk);
        lat++;
      end
      lo = (n - 1) * d + 1;
      hi = n * d;
      chk($sformatf("R4/R5 code %0d latency in range", FILT_VEC[v][11:8]),
          int'(lat >= lo && lat <= hi), 1);
    end
    ext_lvl = 1'b0;
    cfg_filt = 4'd0;
    cyc(2);

    // R4: an agreeing sample restarts the count (code 3, 8 samples)
    cfg_filt = 4'd3;
    cyc(2);
    ext_lvl = 1'b1; cyc(7);
    ext_lvl = 1'b0; cyc(1);
    ext_lvl = 1'b1; cyc(7);
    chk("R4 restart keeps level low", active, 0);
    cyc(1);
    chk("R4 eighth sample flips level", active, 1);
    ext_lvl = 1'b0; cyc(9);
    chk("R4 release filtered", active, 0);

    // R5: no dts strobes, no change
    cfg_filt = 4'd4;
    dts_en = 1'b0;
    ext_lvl = 1'b1; cyc(60);
    chk("R5 stalled without dts_en", active, 0);
    dts_en = 1'b1;
    ext_lvl = 1'b0;
    cfg_filt = 4'd0;
    cyc(2);

    // R8 software set / clear
    pulse(sw_oe_set);
    chk("R8 set raises oe", oe, 1);
    pulse(sw_oe_clr);
    chk("R8 clear lowers oe", oe, 0);
    pulse(sw_oe_set);

    // R3 / R6 combinational fault
    ext_lvl = 1'b1;
    #1;
    chk("R3 active same cycle", active, 1);
    chk("R3 oe low same cycle", oe, 0);
    @(negedge clk);
    pulse(sw_oe_set);
    chk("R6 set ignored in fault", oe, 0);
    ext_lvl = 1'b0;
    cyc(1);
    chk("R6 oe stays low after fault", oe, 0);

    // R7 automatic enable
    cfg_auto = 1'b0;
    pulse(update_evt);
    chk("R7 update without auto", oe, 0);
    cfg_auto = 1'b1;
    ext_lvl = 1'b1;
    pulse(update_evt);
    chk("R7 update during fault", oe, 0);
    ext_lvl = 1'b0;
    pulse(update_evt);
    chk("R7 update after fault", oe, 1);
    cfg_auto = 1'b0;

    // R2 polarity and enable
    cfg_polarity = 1'b0;
    ext_lvl = 1'b1; #1;
    chk("R2 high ignored when active-low", active, 0);
    ext_lvl = 1'b0; #1;
    chk("R2 low is fault when active-low", active, 1);
    cfg_enable = 1'b0; #1;
    chk("R2 disabled masks pin", active, 0);
    sys_brk = 1'b1; #1;
    chk("R2 disabled masks system fault", active, 0);
    cyc(1);
    pulse(sw_oe_set);
    chk("R2 oe settable while disabled", oe, 1);
    sys_brk = 1'b0;
    cfg_enable = 1'b1;
    cfg_polarity = 1'b1;
    cyc(1);

    // R11 system fault
    pulse(sw_oe_set);
    sys_brk = 1'b1; #1;
    chk("R11 system fault active", active, 1);
    chk("R11 system fault drops oe", oe, 0);
    sys_brk = 1'b0;
    cyc(1);

    // R9 / R10 bidirectional pull and disarm (active-low pin)
    cfg_polarity = 1'b0;
    ext_lvl = 1'b1;
    cfg_bidir = 1'b0;
    cyc(1);
    ext_lvl = 1'b0; cyc(2);
    chk("R9 no pull in input mode", pull_low, 0);
    ext_lvl = 1'b1; cyc(1);
    cfg_bidir = 1'b1;
    ext_lvl = 1'b0; cyc(1);
    chk("R9 pull follows fault", pull_low, 1);
    pulse(sw_disarm);
    chk("R10 disarm set", disarmed, 1);
    chk("R10 pull released", pull_low, 0);
    cyc(3);
    chk("R10 disarm held while source active", disarmed, 1);
    ext_lvl = 1'b1; cyc(1);
    chk("R10 hardware re-arms", disarmed, 0);
    chk("R9 no pull after recovery", pull_low, 0);
    ext_lvl = 1'b0; cyc(1);
    chk("R9 pull on new fault", pull_low, 1);
    ext_lvl = 1'b1; cyc(3);
    chk("R9 pull self-sustains on shared pin", active, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule